// File: doc/BRIEF.md
# Instruction Label Propagation Unit

This block works out which in-flight instructions are charged for the switching of one logic cell during power attribution. Each cell input carries an instruction label. A label is a bitmask over the tags of the instructions now in flight. The block takes the cell kind, the logic values on the cell's inputs and one label per input. From these it forms the label of the cell's output net. The rule it applies depends on whether each input holds a controlling or a non-controlling value for that kind of cell.

When two non-empty labels meet, a mode input picks how they merge. One choice keeps only the most recently fetched instruction. The other takes the set union. A register stage can capture the output label on the clock edge to model a storage element. That stage can retain the label, drop it when nothing carries it onward, or act as a sink that discards the label one cycle after it arrives. When the in-flight window advances, the stored label moves down one tag position, so tag order keeps following fetch age.

Top module: `lblp_unit`

## Requirements
- R1: Cell code 0 (buffer/inverter) drives the output label with the label of input A, unchanged, whatever the logic values.
- R2: For cell codes 1 (AND), 2 (OR) and 3 (XOR), when one of the A/B labels is empty the output label equals the other label, whatever the logic values.
- R3: OR with both labels non-empty gives: A=1,B=0 gives label A; A=0,B=1 gives label B; 00 and 11 give the merge of A and B.
- R4: AND with both labels non-empty gives: A=1,B=0 gives label B; A=0,B=1 gives label A; 00 and 11 give the merge of A and B.
- R5: XOR with both labels non-empty always gives the merge of A and B, for every input value.
- R6: Cell code 4 (2-to-1 mux, data 0 on A, data 1 on B, select value S with label S) uses the chosen data label D. The rules are: if label S is empty the output is D; if D is empty the output is label S; otherwise the output is the merge of S and D.
- R7: Bit i of a label is tag i, and a higher bit means a later fetch. Mode 0 (priority) merges to only the highest set bit of A|B. Mode 1 (union) merges to A|B. No output label ever holds a tag absent from all of its input labels.
- R8: Cell codes 5, 6 and 7 yield an empty output label.
- R9: With the load control high, the stored label takes the output label at the rising edge.
- R10: With the sink control high and no load, a stored label is cleared at the next edge, even with hold high.
- R11: Without load, the hold control keeps the stored label. With neither load nor hold, it is cleared at the edge.
- R12: With the window-advance control high at an edge, the value written to the stored label (loaded or held) is shifted right by one bit, and tag 0 is lost.
- R13: A synchronous active-high reset clears the stored label to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cell_kind | input | 3 | Cell code: 0 buffer, 1 AND, 2 OR, 3 XOR, 4 mux |
| merge_mode | input | 1 | 0 priority merge, 1 union merge |
| a_val | input | 1 | Logic value on input A (mux data 0) |
| b_val | input | 1 | Logic value on input B (mux data 1) |
| s_val | input | 1 | Logic value on the mux select |
| lbl_a | input | TAGS | Label of input A |
| lbl_b | input | TAGS | Label of input B |
| lbl_s | input | TAGS | Label of the mux select |
| cap_load | input | 1 | Capture the output label at the edge |
| cap_hold | input | 1 | Keep the stored label when not loading |
| cap_sink | input | 1 | Stored element is a sink; drop its label next edge |
| win_adv | input | 1 | In-flight window advances at this edge |
| lbl_out | output | TAGS | Combinational output-net label |
| lbl_q | output | TAGS | Stored label |

## Verification
The combinational rules are swept exhaustively with a 4-tag configuration. The sweep covers every cell code, every combination of the three logic values and every pair of A/B labels in both merge modes. This includes the empty-label cases that separate R2 from the value-dependent rules, and multi-bit labels that separate priority merging from union. For the mux, every select label is also swept. This separates the "select label only" case from the merge with the chosen data label, and it shows that the unchosen data label never leaks through. The register stage is then driven through a scripted sequence. The sequence covers load, hold, drop, sink clear with hold asserted, window advance on both held and loaded values, and reset over a full label. Together these tell apart the priority of sink over hold and the point where the shift applies.

// File: rtl/lblp_pkg.sv
package lblp_pkg;

    localparam int unsigned TAGS_DEFAULT = 8;

    typedef enum logic [2:0] {
        CK_BUF = 3'd0,
        CK_AND = 3'd1,
        CK_OR  = 3'd2,
        CK_XOR = 3'd3,
        CK_MUX = 3'd4
    } cell_kind_e;

    typedef enum logic {
        MM_PRIO  = 1'b0,
        MM_UNION = 1'b1
    } merge_mode_e;

    typedef struct packed {
        logic load;
        logic hold;
        logic sink;
        logic adv;
    } store_ctl_t;

    function automatic logic kind_is_gate2(input logic [2:0] k);
        return (k == CK_AND) || (k == CK_OR) || (k == CK_XOR);
    endfunction

    function automatic logic kind_is_known(input logic [2:0] k);
        return k <= CK_MUX;
    endfunction

endpackage

// File: rtl/lblp_merge.sv
module lblp_merge
    import lblp_pkg::*;
#(
    parameter int unsigned TAGS = TAGS_DEFAULT
) (
    input  logic [TAGS-1:0] x,
    input  logic [TAGS-1:0] y,
    input  merge_mode_e     mode,
    output logic [TAGS-1:0] z
);

    logic [TAGS-1:0] both;
    logic [TAGS:0]   seen_above;
    logic [TAGS-1:0] newest;

    assign both = x | y;
    assign seen_above[TAGS] = 1'b0;

    // Isolate the highest set bit: a bit survives only if no later tag is set.
    for (genvar i = TAGS - 1; i >= 0; i--) begin : g_top
        assign seen_above[i] = seen_above[i+1] | both[i];
        assign newest[i]     = both[i] & ~seen_above[i+1];
    end

    assign z = (mode == MM_UNION) ? both : newest;

endmodule

// File: rtl/lblp_cell_rule.sv
module lblp_cell_rule
    import lblp_pkg::*;
#(
    parameter int unsigned TAGS = TAGS_DEFAULT
) (
    input  logic [2:0]      kind,
    input  merge_mode_e     mode,
    input  logic            a_val,
    input  logic            b_val,
    input  logic            s_val,
    input  logic [TAGS-1:0] la,
    input  logic [TAGS-1:0] lb,
    input  logic [TAGS-1:0] ls,
    output logic [TAGS-1:0] y
);

    logic [TAGS-1:0] m_ab;
    logic [TAGS-1:0] m_s0;
    logic [TAGS-1:0] m_s1;
    logic            a_nil;
    logic            b_nil;
    logic            s_nil;
    logic            only_a_high;
    logic            only_b_high;

    lblp_merge #(.TAGS(TAGS)) u_m_ab (.x(la), .y(lb), .mode(mode), .z(m_ab));
    lblp_merge #(.TAGS(TAGS)) u_m_s0 (.x(ls), .y(la), .mode(mode), .z(m_s0));
    lblp_merge #(.TAGS(TAGS)) u_m_s1 (.x(ls), .y(lb), .mode(mode), .z(m_s1));

    assign a_nil       = (la == '0);
    assign b_nil       = (lb == '0);
    assign s_nil       = (ls == '0);
    assign only_a_high = a_val & ~b_val;
    assign only_b_high = ~a_val & b_val;

    always_comb begin
        y = '0;
        if (kind_is_gate2(kind) && (a_nil || b_nil)) begin
            y = a_nil ? lb : la;
        end else begin
            case (kind)
                CK_BUF: y = la;
                CK_AND: begin
                    // a 0 on one pin controls the output: charge that pin
                    if (only_a_high)      y = lb;
                    else if (only_b_high) y = la;
                    else                  y = m_ab;
                end
                CK_OR: begin
                    // a 1 on one pin controls the output: charge that pin
                    if (only_a_high)      y = la;
                    else if (only_b_high) y = lb;
                    else                  y = m_ab;
                end
                CK_XOR: y = m_ab;
                CK_MUX: begin
                    if (!s_val) begin
                        if (s_nil)      y = la;
                        else if (a_nil) y = ls;
                        else            y = m_s0;
                    end else begin
                        if (s_nil)      y = lb;
                        else if (b_nil) y = ls;
                        else            y = m_s1;
                    end
                end
                default: y = '0;
            endcase
        end
    end

endmodule

// File: rtl/lblp_store.sv
module lblp_store
    import lblp_pkg::*;
#(
    parameter int unsigned TAGS = TAGS_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  store_ctl_t      ctl,
    input  logic [TAGS-1:0] d,
    output logic [TAGS-1:0] q
);

    logic [TAGS-1:0] pick;
    logic [TAGS-1:0] nxt;

    always_comb begin
        if (ctl.load)
            pick = d;
        else if (ctl.hold && !ctl.sink)
            pick = q;
        else
            pick = '0;
        nxt = ctl.adv ? (pick >> 1) : pick;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/lblp_unit.sv
module lblp_unit
    import lblp_pkg::*;
#(
    parameter int unsigned TAGS = TAGS_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      cell_kind,
    input  logic            merge_mode,
    input  logic            a_val,
    input  logic            b_val,
    input  logic            s_val,
    input  logic [TAGS-1:0] lbl_a,
    input  logic [TAGS-1:0] lbl_b,
    input  logic [TAGS-1:0] lbl_s,
    input  logic            cap_load,
    input  logic            cap_hold,
    input  logic            cap_sink,
    input  logic            win_adv,
    output logic [TAGS-1:0] lbl_out,
    output logic [TAGS-1:0] lbl_q
);

    merge_mode_e mode;
    store_ctl_t  ctl;

    assign mode = merge_mode_e'(merge_mode);
    assign ctl  = '{load: cap_load, hold: cap_hold, sink: cap_sink, adv: win_adv};

    lblp_cell_rule #(.TAGS(TAGS)) u_rule (
        .kind  (cell_kind),
        .mode  (mode),
        .a_val (a_val),
        .b_val (b_val),
        .s_val (s_val),
        .la    (lbl_a),
        .lb    (lbl_b),
        .ls    (lbl_s),
        .y     (lbl_out)
    );

    lblp_store #(.TAGS(TAGS)) u_store (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .d   (lbl_out),
        .q   (lbl_q)
    );

endmodule

// File: rtl/lblp_chk.sv
module lblp_chk #(
    parameter int unsigned TAGS = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      cell_kind,
    input logic            merge_mode,
    input logic [TAGS-1:0] lbl_a,
    input logic [TAGS-1:0] lbl_b,
    input logic [TAGS-1:0] lbl_s,
    input logic            cap_load,
    input logic            cap_hold,
    input logic            cap_sink,
    input logic            win_adv,
    input logic [TAGS-1:0] lbl_out,
    input logic [TAGS-1:0] lbl_q
);

    // R7: no tag appears on the output that no input carried
    a_r7_no_new_tag: assert property (@(posedge clk) disable iff (rst)
        (lbl_out & ~(lbl_a | lbl_b | lbl_s)) == '0);

    // R7: priority mode keeps single-tag labels single
    a_r7_prio_single: assert property (@(posedge clk) disable iff (rst)
        (!merge_mode && $countones(lbl_a) <= 1 && $countones(lbl_b) <= 1
         && $countones(lbl_s) <= 1) |-> $onehot0(lbl_out));

    // R2: empty A label on a two-input gate passes B through
    a_r2_empty_side: assert property (@(posedge clk) disable iff (rst)
        ((cell_kind == 3'd1 || cell_kind == 3'd2 || cell_kind == 3'd3)
         && lbl_a == '0) |-> lbl_out == lbl_b);

    // R8: unused cell codes give an empty label
    a_r8_unused_kind: assert property (@(posedge clk) disable iff (rst)
        (cell_kind > 3'd4) |-> lbl_out == '0);

    // R9, R12: a load captures the output label, shifted when the window moves
    a_r9_load: assert property (@(posedge clk) disable iff (rst)
        cap_load |=> lbl_q == ($past(win_adv) ? ($past(lbl_out) >> 1) : $past(lbl_out)));

    // R10: a sink without a load is empty after the edge
    a_r10_sink_drop: assert property (@(posedge clk) disable iff (rst)
        (!cap_load && cap_sink) |=> lbl_q == '0);

    // R11: neither load nor hold empties the stored label
    a_r11_no_transfer: assert property (@(posedge clk) disable iff (rst)
        (!cap_load && !cap_hold) |=> lbl_q == '0);

    // R11: a hold with no window move keeps the label stable
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!cap_load && cap_hold && !cap_sink && !win_adv) |=> $stable(lbl_q));

endmodule

bind lblp_unit lblp_chk #(.TAGS(TAGS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cell_kind  (cell_kind),
    .merge_mode (merge_mode),
    .lbl_a      (lbl_a),
    .lbl_b      (lbl_b),
    .lbl_s      (lbl_s),
    .cap_load   (cap_load),
    .cap_hold   (cap_hold),
    .cap_sink   (cap_sink),
    .win_adv    (win_adv),
    .lbl_out    (lbl_out),
    .lbl_q      (lbl_q)
);

// File: tb/sim_lblp_unit.sv
`timescale 1ns/1ps
module sim_lblp_unit;

    localparam int unsigned TAGS = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [2:0]      cell_kind;
    logic            merge_mode;
    logic            a_val, b_val, s_val;
    logic [TAGS-1:0] lbl_a, lbl_b, lbl_s;
    logic            cap_load, cap_hold, cap_sink, win_adv;
    logic [TAGS-1:0] lbl_out, lbl_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lblp_unit #(.TAGS(TAGS)) u0 (
        .clk(clk), .rst(rst), .cell_kind(cell_kind), .merge_mode(merge_mode),
        .a_val(a_val), .b_val(b_val), .s_val(s_val),
        .lbl_a(lbl_a), .lbl_b(lbl_b), .lbl_s(lbl_s),
        .cap_load(cap_load), .cap_hold(cap_hold), .cap_sink(cap_sink),
        .win_adv(win_adv), .lbl_out(lbl_out), .lbl_q(lbl_q)
    );

    function automatic logic [TAGS-1:0] rmerge(input logic [TAGS-1:0] x, input logic [TAGS-1:0] y,
                                               input logic m);
        logic [TAGS-1:0] u;
        u = x | y;
        if (m) return u;
        for (int i = TAGS - 1; i >= 0; i--)
            if (u[i]) return TAGS'(1) << i;
        return '0;
    endfunction

    function automatic logic [TAGS-1:0] rexp(input int k, input logic m, input logic av,
                                             input logic bv, input logic sv,
                                             input logic [TAGS-1:0] la, input logic [TAGS-1:0] lb,
                                             input logic [TAGS-1:0] ls);
        logic [TAGS-1:0] d;
        if (k == 0) return la;                               // R1
        if (k >= 1 && k <= 3) begin
            if (la == 0) return lb;                          // R2
            if (lb == 0) return la;
            if (k == 3) return rmerge(la, lb, m);            // R5
            if (k == 2) begin                                // R3
                if (av && !bv) return la;
                if (!av && bv) return lb;
                return rmerge(la, lb, m);
            end
            if (av && !bv) return lb;                        // R4
            if (!av && bv) return la;
            return rmerge(la, lb, m);
        end
        if (k == 4) begin                                    // R6
            d = sv ? lb : la;
            if (ls == 0) return d;
            if (d == 0) return ls;
            return rmerge(ls, d, m);
        end
        return '0;                                           // R8
    endfunction

    function automatic string req_of(input int k, input logic [TAGS-1:0] la, input logic [TAGS-1:0] lb);
        if (k == 0) return "R1";
        if (k >= 1 && k <= 3 && (la == 0 || lb == 0)) return "R2";
        if (k == 1) return "R4";
        if (k == 2) return "R3";
        if (k == 3) return "R5";
        if (k == 4) return "R6";
        return "R8";
    endfunction

    task automatic cmp(input string req, input logic [TAGS-1:0] act, input logic [TAGS-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (kind %0d mode %0d vals %b%b%b a %b b %b s %b)",
                     req, act, exp, cell_kind, merge_mode, a_val, b_val, s_val, lbl_a, lbl_b, lbl_s);
        end
    endtask

    task automatic step(input logic ld, input logic hd, input logic sk, input logic ad,
                        input logic [TAGS-1:0] d, input string req, input logic [TAGS-1:0] exp);
        @(negedge clk);
        cell_kind = 3'd0; merge_mode = 1'b1; lbl_a = d;
        cap_load = ld; cap_hold = hd; cap_sink = sk; win_adv = ad;
        @(posedge clk);
        #1;
        cmp(req, lbl_q, exp);
    endtask

    initial begin
        #(5 * 150000);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cell_kind = '0; merge_mode = 1'b0;
        a_val = 0; b_val = 0; s_val = 0; lbl_a = '0; lbl_b = '0; lbl_s = '0;
        cap_load = 0; cap_hold = 0; cap_sink = 0; win_adv = 0;
        repeat (3) @(posedge clk);
        #1;
        cmp("R13", lbl_q, '0);
        @(negedge clk);
        rst = 1'b0;

        // Exhaustive combinational sweep; register stage idles (neither load nor hold)
        for (int k = 0; k < 8; k++)
            for (int m = 0; m < 2; m++)
                for (int v = 0; v < 8; v++)
                    for (int a = 0; a < (1 << TAGS); a++)
                        for (int b = 0; b < (1 << TAGS); b++)
                            for (int s = 0; s < ((k == 4) ? (1 << TAGS) : 1); s++) begin
                                cell_kind = 3'(k); merge_mode = m[0];
                                a_val = v[0]; b_val = v[1]; s_val = v[2];
                                lbl_a = TAGS'(a); lbl_b = TAGS'(b); lbl_s = TAGS'(s);
                                #0.5;
                                cmp(req_of(k, lbl_a, lbl_b), lbl_out,
                                    rexp(k, m[0], v[0], v[1], v[2], TAGS'(a), TAGS'(b), TAGS'(s)));
                            end

        // R7: explicit priority versus union on multi-bit labels
        cell_kind = 3'd3; lbl_a = 4'b0101; lbl_b = 4'b0011; lbl_s = '0;
        merge_mode = 1'b0; #0.5; cmp("R7", lbl_out, 4'b0100);
        merge_mode = 1'b1; #0.5; cmp("R7", lbl_out, 4'b0111);

        // Register stage
        step(1, 0, 0, 0, 4'b1010, "R9",  4'b1010);
        step(0, 1, 0, 0, 4'b0001, "R11", 4'b1010);
        step(0, 1, 0, 1, 4'b0001, "R12", 4'b0101);
        step(0, 1, 0, 1, 4'b0001, "R12", 4'b0010);
        step(0, 0, 0, 0, 4'b0001, "R11", 4'b0000);
        step(1, 0, 1, 0, 4'b0110, "R9",  4'b0110);
        step(0, 1, 1, 0, 4'b0001, "R10", 4'b0000);
        step(1, 0, 1, 0, 4'b1001, "R9",  4'b1001);
        step(1, 0, 1, 0, 4'b0011, "R10", 4'b0011);
        step(1, 0, 0, 1, 4'b1011, "R12", 4'b0101);
        step(1, 1, 0, 0, 4'b1111, "R9",  4'b1111);
        @(negedge clk);
        rst = 1'b1; cap_load = 1'b1; lbl_a = 4'b0111;
        @(posedge clk);
        #1;
        cmp("R13", lbl_q, 4'b0000);
        @(negedge clk);
        rst = 1'b0; cap_load = 1'b0; cap_hold = 1'b1;
        @(posedge clk);
        #1;
        cmp("R13", lbl_q, 4'b0000);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule